// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside a page-write sequencer and watches every byte strobe (15-bit address, 8-bit data) that the sequencer accepts into its page buffer. A load may open with one of two fixed key sequences. The three-step lock key is (5555h, AAh), (2AAAh, 55h), (5555h, A0h). The six-step unlock key is (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (5555h, 20h). Key bytes are reported as command bytes, which the sequencer drops. Every other byte is data. If a key breaks off part way, the bytes matched so far are handed back to the sequencer as data.

The block holds a persistent protect flag. An ordinary reset leaves the flag alone, which models storage that survives a power cycle. Only the factory-initialise input clears it. When a load closes, the block tells the sequencer whether the load may be committed to the array. A refused load still runs the programming timer but stores nothing. A key found in a load changes the flag only when the following write period ends.

The sequencer enforces the byte-load gap limit and asserts a close pulse when the load window ends. This applies to key bytes and data bytes alike, so a key cut short by a timeout is abandoned through that close. The sequencer never asserts a strobe and a close in the same cycle.

Top module: `wp_cmd_detect`

## Requirements
- R1: When a load's first three strobes are (5555h,AAh), (2AAAh,55h), (5555h,A0h), `byte_cmd` is 1 during each of those strobes.
- R2: When a load's first six strobes are (5555h,AAh), (2AAAh,55h), (5555h,80h), (5555h,AAh), (2AAAh,55h), (5555h,20h), `byte_cmd` is 1 during each of them.
- R3: A strobe that fails to match the next key step has `byte_cmd` 0 and `rewind_cnt` equal to the number of key bytes matched before it in this load (0 to 5). Every later strobe of that load has `byte_cmd` 0 and `rewind_cnt` 0.
- R4: If `ld_close` arrives while a key is only partly matched, `rewind_cnt` during the close equals the number of matched bytes, and the load is judged as having no key.
- R5: During `ld_close`, `commit_ok` is 1 if the flag is 0 or the load opened with a complete lock or unlock key, and 0 otherwise. Outside `ld_close`, `commit_ok` is 0.
- R6: A load that carries a complete lock key sets `lock_state` to 1, and one that carries a complete unlock key sets it to 0. The change happens on the first `prog_done` after that load's close and not before.
- R7: `rst` clears key progress and any pending flag change, but leaves `lock_state` as it was.
- R8: `factory_init` clears `lock_state` to 0 on the next edge and discards any pending flag change.
- R9: Once a key is complete, or a load has begun with a non-key byte, key-valued bytes later in that load are data (`byte_cmd` 0).
- R10: A `prog_done` after a load with no complete key leaves `lock_state` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not touch the protect flag) |
| factory_init | input | 1 | Clears the protect flag and any pending change |
| ld_stb | input | 1 | One byte strobe of the current load |
| ld_addr | input | 15 | Address of the strobed byte |
| ld_data | input | 8 | Data of the strobed byte |
| ld_close | input | 1 | Load window closes, programming period starts |
| prog_done | input | 1 | Programming period has ended |
| byte_cmd | output | 1 | Current strobe is a key byte to be dropped |
| rewind_cnt | output | 3 | Earlier key bytes of this load to be reclassed as data |
| commit_ok | output | 1 | With `ld_close`: the load may be written to the array |
| lock_state | output | 1 | Persistent protect flag |

## Verification
The key matcher is driven with complete lock and unlock keys, keys that break at the first, third and fifth step, a key cut short by the load closing, and key-valued bytes placed after the head of a load. Together these show that classification depends on position in the load, that the lock and unlock keys share a common prefix and split correctly, and that the rewind count is exact. The same loads are run both unlocked and locked. This separates the commit decision from the key detection and shows that the flag moves only on the `prog_done` that follows a keyed load. Directed runs place `rst` and `factory_init` between a keyed close and its `prog_done`, which shows that the pending change is dropped while the flag itself survives a reset.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int KEY_AW     = 15;
    localparam int KEY_DW     = 8;
    localparam int UNLOCK_LEN = 6;
    localparam int LOCK_FORK  = 2;   // lock key departs from unlock key at this step
    localparam int STEP_W     = $clog2(UNLOCK_LEN);

    typedef struct packed {
        logic [KEY_AW-1:0] addr;
        logic [KEY_DW-1:0] data;
    } key_t;

    typedef struct packed {
        logic hit_unlock;
        logic hit_lock;
    } match_t;

    typedef enum logic [1:0] {
        SQ_HUNT,
        SQ_GOT_LOCK,
        SQ_GOT_UNLOCK,
        SQ_PLAIN
    } sq_t;

    typedef enum logic [1:0] {
        CHG_NONE,
        CHG_LOCK,
        CHG_UNLOCK
    } chg_t;

    function automatic key_t unlock_key(input int idx);
        key_t k;
        case (idx)
            0, 3:    k = '{addr: 15'h5555, data: 8'hAA};
            1, 4:    k = '{addr: 15'h2AAA, data: 8'h55};
            2:       k = '{addr: 15'h5555, data: 8'h80};
            default: k = '{addr: 15'h5555, data: 8'h20};
        endcase
        return k;
    endfunction

    function automatic key_t lock_final();
        return '{addr: 15'h5555, data: 8'hA0};
    endfunction

endpackage

// File: rtl/wpc_key_match.sv
module wpc_key_match
    import wpc_pkg::*;
#(
    parameter int ADDR_W = KEY_AW,
    parameter int DATA_W = KEY_DW
) (
    input  logic [STEP_W-1:0] step,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output match_t            hit
);
    localparam int PAD = (2 ** STEP_W) - UNLOCK_LEN;
    localparam key_t LK = lock_final();

    logic [UNLOCK_LEN-1:0]  step_hit;
    logic [2**STEP_W-1:0]   hit_pad;

    for (genvar i = 0; i < UNLOCK_LEN; i++) begin : g_step
        localparam key_t K = unlock_key(i);
        assign step_hit[i] = (addr == ADDR_W'(K.addr)) && (data == DATA_W'(K.data));
    end

    if (PAD > 0) begin : g_pad
        assign hit_pad = {{PAD{1'b0}}, step_hit};
    end else begin : g_nopad
        assign hit_pad = step_hit;
    end

    always_comb begin
        hit.hit_unlock = hit_pad[step];
        hit.hit_lock   = (step == STEP_W'(LOCK_FORK))
                       && (addr == ADDR_W'(LK.addr))
                       && (data == DATA_W'(LK.data));
    end
endmodule

// File: rtl/wpc_seq_track.sv
module wpc_seq_track
    import wpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_stb,
    input  logic              ld_close,
    input  match_t            hit,
    output logic [STEP_W-1:0] step,
    output logic              byte_cmd,
    output logic [STEP_W-1:0] rewind_cnt,
    output chg_t              close_chg
);
    sq_t               st_q, st_d;
    logic [STEP_W-1:0] step_q, step_d;

    assign step = step_q;

    always_comb begin
        st_d       = st_q;
        step_d     = step_q;
        byte_cmd   = 1'b0;
        rewind_cnt = '0;
        close_chg  = CHG_NONE;
        if (ld_close) begin
            if (st_q == SQ_HUNT) rewind_cnt = step_q;
            if (st_q == SQ_GOT_LOCK)   close_chg = CHG_LOCK;
            if (st_q == SQ_GOT_UNLOCK) close_chg = CHG_UNLOCK;
            st_d   = SQ_HUNT;
            step_d = '0;
        end else if (ld_stb && st_q == SQ_HUNT) begin
            if (hit.hit_lock) begin
                byte_cmd = 1'b1;
                st_d     = SQ_GOT_LOCK;
                step_d   = '0;
            end else if (hit.hit_unlock) begin
                byte_cmd = 1'b1;
                if (step_q == STEP_W'(UNLOCK_LEN - 1)) begin
                    st_d   = SQ_GOT_UNLOCK;
                    step_d = '0;
                end else begin
                    step_d = step_q + 1'b1;
                end
            end else begin
                rewind_cnt = step_q;
                st_d       = SQ_PLAIN;
                step_d     = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_HUNT;
            step_q <= '0;
        end else begin
            st_q   <= st_d;
            step_q <= step_d;
        end
    end
endmodule

// File: rtl/wpc_lock_store.sv
module wpc_lock_store
    import wpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic factory_init,
    input  logic ld_close,
    input  chg_t close_chg,
    input  logic prog_done,
    output logic lock_q
);
    chg_t pend_q;

    always_ff @(posedge clk) begin
        if (factory_init) begin
            lock_q <= 1'b0;
            pend_q <= CHG_NONE;
        end else begin
            if (rst)            pend_q <= CHG_NONE;
            else if (ld_close)  pend_q <= close_chg;
            else if (prog_done) pend_q <= CHG_NONE;

            if (!rst && prog_done) begin
                if (pend_q == CHG_LOCK)   lock_q <= 1'b1;
                if (pend_q == CHG_UNLOCK) lock_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wp_cmd_detect.sv
module wp_cmd_detect
    import wpc_pkg::*;
#(
    parameter int ADDR_W = KEY_AW,
    parameter int DATA_W = KEY_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              factory_init,
    input  logic              ld_stb,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_close,
    input  logic              prog_done,
    output logic              byte_cmd,
    output logic [STEP_W-1:0] rewind_cnt,
    output logic              commit_ok,
    output logic              lock_state
);
    match_t            hit;
    logic [STEP_W-1:0] step;
    chg_t              close_chg;

    wpc_key_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .step (step),
        .addr (ld_addr),
        .data (ld_data),
        .hit  (hit)
    );

    wpc_seq_track u_track (
        .clk        (clk),
        .rst        (rst),
        .ld_stb     (ld_stb),
        .ld_close   (ld_close),
        .hit        (hit),
        .step       (step),
        .byte_cmd   (byte_cmd),
        .rewind_cnt (rewind_cnt),
        .close_chg  (close_chg)
    );

    wpc_lock_store u_store (
        .clk          (clk),
        .rst          (rst),
        .factory_init (factory_init),
        .ld_close     (ld_close),
        .close_chg    (close_chg),
        .prog_done    (prog_done),
        .lock_q       (lock_state)
    );

    assign commit_ok = ld_close && (!lock_state || close_chg != CHG_NONE);
endmodule

// File: rtl/wp_cmd_detect_chk.sv
module wp_cmd_detect_chk
    import wpc_pkg::*;
#(
    parameter int ADDR_W = KEY_AW,
    parameter int DATA_W = KEY_DW
) (
    input logic              clk,
    input logic              rst,
    input logic              factory_init,
    input logic              ld_stb,
    input logic [ADDR_W-1:0] ld_addr,
    input logic [DATA_W-1:0] ld_data,
    input logic              ld_close,
    input logic              prog_done,
    input logic              byte_cmd,
    input logic [STEP_W-1:0] rewind_cnt,
    input logic              commit_ok,
    input logic              lock_state
);
    // R1
    cmd_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        byte_cmd |-> (ld_stb && !ld_close));

    // R3
    rewind_is_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rewind_cnt != '0) |-> !byte_cmd);

    // R4
    rewind_range_chk: assert property (@(posedge clk) disable iff (rst)
        rewind_cnt <= STEP_W'(UNLOCK_LEN - 1));

    // R5
    commit_at_close_chk: assert property (@(posedge clk) disable iff (rst)
        commit_ok |-> ld_close);

    // R5
    unlocked_commits_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_close && !lock_state) |-> commit_ok);

    // R6
    lock_moves_late_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_state) |-> $past(prog_done || factory_init));

    // R8
    factory_clears_chk: assert property (@(posedge clk) disable iff (rst)
        factory_init |=> !lock_state);

    // R1
    strobe_close_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(ld_stb && ld_close));
endmodule

bind wp_cmd_detect wp_cmd_detect_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_wp_cmd_detect.sv
module sim_wp_cmd_detect;
    localparam int OP_S = 0, OP_C = 1, OP_D = 2;
    localparam int VW = 35;
    localparam int NV = 41;
    // {req[3:0], op[1:0], addr[14:0], data[7:0], e_cmd, e_rew[2:0], e_commit, e_lock}
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd1, 2'd0, 15'h5555, 8'hAA, 1'b1, 3'd0, 1'b0, 1'b0},  // R1 lock key
        {4'd1, 2'd0, 15'h2AAA, 8'h55, 1'b1, 3'd0, 1'b0, 1'b0},
        {4'd1, 2'd0, 15'h5555, 8'hA0, 1'b1, 3'd0, 1'b0, 1'b0},
        {4'd9, 2'd0, 15'h0100, 8'h11, 1'b0, 3'd0, 1'b0, 1'b0},  // R9 data after key
        {4'd6, 2'd1, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0},  // R6 not yet locked
        {4'd6, 2'd2, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1},  // R6 locks at done
        {4'd3, 2'd0, 15'h0200, 8'h22, 1'b0, 3'd0, 1'b0, 1'b1},  // R3 no key
        {4'd5, 2'd1, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1},  // R5 locked refuse
        {4'd10,2'd2, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1},  // R10
        {4'd1, 2'd0, 15'h5555, 8'hAA, 1'b1, 3'd0, 1'b0, 1'b1},  // R1 while locked
        {4'd1, 2'd0, 15'h2AAA, 8'h55, 1'b1, 3'd0, 1'b0, 1'b1},
        {4'd1, 2'd0, 15'h5555, 8'hA0, 1'b1, 3'd0, 1'b0, 1'b1},
        {4'd9, 2'd0, 15'h5555, 8'hAA, 1'b0, 3'd0, 1'b0, 1'b1},  // R9 key value as data
        {4'd5, 2'd1, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b1, 1'b1},  // R5 keyed commit
        {4'd6, 2'd2, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1},
        {4'd3, 2'd0, 15'h5555, 8'hAA, 1'b1, 3'd0, 1'b0, 1'b1},  // R3 break at step 2
        {4'd3, 2'd0, 15'h2AAA, 8'h55, 1'b1, 3'd0, 1'b0, 1'b1},
        {4'd3, 2'd0, 15'h5555, 8'h33, 1'b0, 3'd2, 1'b0, 1'b1},
        {4'd3, 2'd0, 15'h2AAA, 8'h55, 1'b0, 3'd0, 1'b0, 1'b1},
        {4'd5, 2'd1, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1},
        {4'd10,2'd2, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1},
        {4'd2, 2'd0, 15'h5555, 8'hAA, 1'b1, 3'd0, 1'b0, 1'b1},  // R2 unlock key
        {4'd2, 2'd0, 15'h2AAA, 8'h55, 1'b1, 3'd0, 1'b0, 1'b1},
        {4'd2, 2'd0, 15'h5555, 8'h80, 1'b1, 3'd0, 1'b0, 1'b1},
        {4'd2, 2'd0, 15'h5555, 8'hAA, 1'b1, 3'd0, 1'b0, 1'b1},
        {4'd2, 2'd0, 15'h2AAA, 8'h55, 1'b1, 3'd0, 1'b0, 1'b1},
        {4'd2, 2'd0, 15'h5555, 8'h20, 1'b1, 3'd0, 1'b0, 1'b1},
        {4'd9, 2'd0, 15'h0300, 8'h44, 1'b0, 3'd0, 1'b0, 1'b1},
        {4'd5, 2'd1, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b1, 1'b1},
        {4'd6, 2'd2, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0},  // R6 unlocks at done
        {4'd4, 2'd0, 15'h5555, 8'hAA, 1'b1, 3'd0, 1'b0, 1'b0},  // R4 cut by close
        {4'd4, 2'd1, 15'h0000, 8'h00, 1'b0, 3'd1, 1'b1, 1'b0},
        {4'd3, 2'd0, 15'h5555, 8'hAA, 1'b1, 3'd0, 1'b0, 1'b0},  // R3 break at step 4
        {4'd3, 2'd0, 15'h2AAA, 8'h55, 1'b1, 3'd0, 1'b0, 1'b0},
        {4'd3, 2'd0, 15'h5555, 8'h80, 1'b1, 3'd0, 1'b0, 1'b0},
        {4'd3, 2'd0, 15'h5555, 8'hAA, 1'b1, 3'd0, 1'b0, 1'b0},
        {4'd3, 2'd0, 15'h2AAA, 8'h56, 1'b0, 3'd4, 1'b0, 1'b0},
        {4'd5, 2'd1, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0},
        {4'd10,2'd2, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0},
        {4'd3, 2'd0, 15'h5556, 8'hAA, 1'b0, 3'd0, 1'b0, 1'b0},  // R3 wrong address
        {4'd5, 2'd1, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst, factory_init, ld_stb, ld_close, prog_done;
    logic [14:0] ld_addr;
    logic [7:0]  ld_data;
    logic        byte_cmd, commit_ok, lock_state;
    logic [2:0]  rewind_cnt;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    wp_cmd_detect u0 (
        .clk(clk), .rst(rst), .factory_init(factory_init),
        .ld_stb(ld_stb), .ld_addr(ld_addr), .ld_data(ld_data),
        .ld_close(ld_close), .prog_done(prog_done),
        .byte_cmd(byte_cmd), .rewind_cnt(rewind_cnt),
        .commit_ok(commit_ok), .lock_state(lock_state)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ld_stb = 0; ld_close = 0; prog_done = 0;
        ld_addr = '0; ld_data = '0;
    endtask

    task automatic apply(input int op, input logic [14:0] a, input logic [7:0] d,
                         input int ecmd, input int erew, input int ecom, input int elock,
                         input string tag);
        int c, r, m;
        @(negedge clk);
        ld_stb    = (op == OP_S);
        ld_close  = (op == OP_C);
        prog_done = (op == OP_D);
        ld_addr   = a;
        ld_data   = d;
        #2;
        c = int'(byte_cmd); r = int'(rewind_cnt); m = int'(commit_ok);
        @(negedge clk);
        idle_inputs();
        chk({tag, " byte_cmd"},   c, ecmd);
        chk({tag, " rewind_cnt"}, r, erew);
        chk({tag, " commit_ok"},  m, ecom);
        chk({tag, " lock_state"}, int'(lock_state), elock);
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
    endtask

    task automatic pulse_factory();
        @(negedge clk); factory_init = 1;
        @(negedge clk); factory_init = 0;
    endtask

    task automatic lock_key_close(input string tag);
        apply(OP_S, 15'h5555, 8'hAA, 1, 0, 0, int'(lock_state), tag);
        apply(OP_S, 15'h2AAA, 8'h55, 1, 0, 0, int'(lock_state), tag);
        apply(OP_S, 15'h5555, 8'hA0, 1, 0, 0, int'(lock_state), tag);
        apply(OP_C, 15'h0, 8'h0, 0, 0, 1, int'(lock_state), tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1; factory_init = 1;
        repeat (3) @(negedge clk);
        factory_init = 0;
        @(negedge clk);
        rst = 0;
        #2;
        // R7 R8 reset state
        chk("R8 reset lock_state", int'(lock_state), 0);
        chk("R7 reset byte_cmd",   int'(byte_cmd), 0);
        chk("R7 reset rewind_cnt", int'(rewind_cnt), 0);
        chk("R5 reset commit_ok",  int'(commit_ok), 0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            apply(int'(v[30:29]), v[28:14], v[13:6], int'(v[5]), int'(v[4:2]),
                  int'(v[1]), int'(v[0]), $sformatf("R%0d vec %0d", v[34:31], i));
        end

        // R7: reset mid key restarts matching
        apply(OP_S, 15'h5555, 8'hAA, 1, 0, 0, 0, "R7 pre");
        apply(OP_S, 15'h2AAA, 8'h55, 1, 0, 0, 0, "R7 pre");
        pulse_rst();
        apply(OP_S, 15'h5555, 8'hA0, 0, 0, 0, 0, "R7 after rst");
        apply(OP_C, 15'h0, 8'h0, 0, 0, 1, 0, "R7 close");

        // R7: reset drops pending lock
        lock_key_close("R7 keyed");
        pulse_rst();
        apply(OP_D, 15'h0, 8'h0, 0, 0, 0, 0, "R7 pending dropped");

        // R7: reset keeps flag
        lock_key_close("R6 keyed");
        apply(OP_D, 15'h0, 8'h0, 0, 0, 0, 1, "R6 lock set");
        pulse_rst();
        #1;
        chk("R7 flag survives rst", int'(lock_state), 1);

        // R8: factory init clears flag and pending change
        pulse_factory();
        #1;
        chk("R8 flag cleared", int'(lock_state), 0);
        lock_key_close("R8 keyed");
        pulse_factory();
        apply(OP_D, 15'h0, 8'h0, 0, 0, 0, 0, "R8 pending dropped");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule